// File: doc/BRIEF.md
# ULPI Transceiver Start-Up Sequencer

This block is the transceiver-side control logic that brings a ULPI physical layer out of reset and hands the shared data bus to the link. While its active-low reset input is low it keeps the bus released: DIR low and the data bus output enable low. Once reset is released, the release passes through a two-flop synchronizer. The block then claims the bus by raising DIR and drives IDLE (all zeros) on it. It holds the bus until its clock source reports lock.

Lock comes from one of two sources, chosen by a parameter. The first is a built-in counter of reference-clock edges, which stands in for an analog PLL. The second is an external lock indication, synchronized to the clock. After lock, the block gives up the bus only on a cycle where the link's STP input is low, and it keeps DIR high for as long as the link holds STP. The cycle after DIR falls is a turnaround cycle in which neither side drives the bus. The block then reports itself ready, and it checks that the link is driving IDLE in that first operational cycle. If the bus is not IDLE in that cycle, it sets a sticky protocol-error flag.

All waits are counted in clock edges. If the clock starts late, the sequence is therefore measured from the first clock edges and not from the release of reset.

Top module: `ulpi_startup_seq`

## Requirements
- R1: While `rst_n` is low, `dir`, `phy_data_oe`, `ready` and `proto_err` are all 0, and they take these values as soon as `rst_n` falls, without waiting for a clock edge.
- R2: A released reset passes through a two-flop synchronizer. `dir` stays 0 after the first and second rising edges that follow the release, and it rises after the third.
- R3: Whenever `dir` is 1, `phy_data_oe` is 1 and `phy_data` is 8'h00 (IDLE).
- R4: With the internal lock counter (`USE_EXT_LOCK`=0) and `link_stp` low, `dir` falls at rising edge number `LOCK_CYCLES`+4 after the release, counting the first edge after the release as 1.
- R5: After lock, `dir` falls only at a rising edge where `link_stp` is sampled low. While `link_stp` stays high, `dir` stays high indefinitely.
- R6: After `dir` falls there is exactly one cycle with `dir`, `phy_data_oe` and `ready` all 0. `ready` rises at the next edge and then stays 1 until reset.
- R7: `link_data` is sampled at the end of the first cycle in which `ready` is 1. If it is nonzero, `proto_err` becomes 1 and stays 1 until reset. The value of `link_data` in any other cycle has no effect.
- R8: With `USE_EXT_LOCK`=1, `pll_lock` passes through two flops. When the block is already waiting for lock and `link_stp` is low, `dir` falls at the fourth rising edge after `pll_lock` rises.
- R9: Asserting reset from the operational state returns the block to its reset state, clearing `proto_err`. The next release replays the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-derived clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, released through a synchronizer |
| pll_lock | input | 1 | External lock indication (used when USE_EXT_LOCK=1) |
| link_stp | input | 1 | STP driven by the link |
| link_data | input | DATA_W | Data bus value as driven by the link |
| dir | output | 1 | Bus direction: 1 while the transceiver owns the bus |
| phy_data | output | DATA_W | Data the transceiver drives (IDLE during start-up) |
| phy_data_oe | output | 1 | Output enable for phy_data |
| ready | output | 1 | High once the hand-off is complete |
| proto_err | output | 1 | Sticky flag: link did not drive IDLE after the turnaround |

## Verification
The bench counts edges from a reset release placed between clock edges. A synchronizer that is one stage short or one stage long would therefore show `dir` rising one edge early or one edge late, and a lock counter that is off by one would move the fall of `dir` by the same amount. It holds STP high for far longer than the lock time to catch a design that drops `dir` on lock alone. It also drives a nonzero bus both in the first ready cycle and in later cycles, to catch an error check that samples the wrong cycle or is not sticky. Reset is asserted mid-cycle from the operational state, and all outputs are checked before the next edge, which exposes a reset that acts only synchronously.

// File: rtl/ulpi_su_pkg.sv
package ulpi_su_pkg;
  typedef enum logic [2:0] {
    SU_RESET     = 3'd0,
    SU_WAIT_LOCK = 3'd1,
    SU_WAIT_STP  = 3'd2,
    SU_TURN      = 3'd3,
    SU_OPER      = 3'd4
  } su_state_e;
endpackage

// File: rtl/ulpi_su_rst_sync.sv
module ulpi_su_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic released
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign released = chain_q[STAGES-1];
endmodule

// File: rtl/ulpi_su_lock_src.sv
module ulpi_su_lock_src #(
  parameter bit USE_EXT_LOCK = 1'b0,
  parameter int LOCK_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic released,
  input  logic ext_lock,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  generate
    if (USE_EXT_LOCK) begin : g_ext
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], ext_lock};
      end
      assign locked = sync_q[1];
    end else begin : g_cnt
      logic [CW-1:0] cnt_q;
      logic          unused_ext;
      assign unused_ext = ext_lock;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (!released)               cnt_q <= '0;
        else if (cnt_q != CW'(LOCK_CYCLES)) cnt_q <= cnt_q + 1'b1;
      end
      assign locked = (cnt_q == CW'(LOCK_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/ulpi_su_fsm.sv
module ulpi_su_fsm
  import ulpi_su_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic released,
  input  logic locked,
  input  logic stp,
  output logic dir,
  output logic ready,
  output logic first_oper
);
  su_state_e st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      SU_RESET:     st_nx = SU_WAIT_LOCK;
      SU_WAIT_LOCK: if (locked) st_nx = SU_WAIT_STP;
      SU_WAIT_STP:  if (!stp)   st_nx = SU_TURN;
      SU_TURN:      st_nx = SU_OPER;
      SU_OPER:      st_nx = SU_OPER;
      default:      st_nx = SU_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SU_RESET;
      dir        <= 1'b0;
      ready      <= 1'b0;
      first_oper <= 1'b0;
    end else if (!released) begin
      st_q       <= SU_RESET;
      dir        <= 1'b0;
      ready      <= 1'b0;
      first_oper <= 1'b0;
    end else begin
      st_q       <= st_nx;
      dir        <= (st_nx == SU_WAIT_LOCK) || (st_nx == SU_WAIT_STP);
      ready      <= (st_nx == SU_OPER);
      first_oper <= (st_q == SU_TURN);
    end
  end
endmodule

// File: rtl/ulpi_su_idle_chk.sv
module ulpi_su_idle_chk #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              released,
  input  logic              first_oper,
  input  logic [DATA_W-1:0] link_data,
  output logic              proto_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               proto_err <= 1'b0;
    else if (!released)                       proto_err <= 1'b0;
    else if (first_oper && (link_data != '0)) proto_err <= 1'b1;
  end
endmodule

// File: rtl/ulpi_startup_seq.sv
module ulpi_startup_seq #(
  parameter int DATA_W       = 8,
  parameter bit USE_EXT_LOCK = 1'b0,
  parameter int LOCK_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_lock,
  input  logic              link_stp,
  input  logic [DATA_W-1:0] link_data,
  output logic              dir,
  output logic [DATA_W-1:0] phy_data,
  output logic              phy_data_oe,
  output logic              ready,
  output logic              proto_err
);
  logic released, locked, first_oper, dir_q;

  ulpi_su_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .released(released));

  ulpi_su_lock_src #(.USE_EXT_LOCK(USE_EXT_LOCK), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .released(released), .ext_lock(pll_lock), .locked(locked));

  ulpi_su_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .released(released), .locked(locked), .stp(link_stp),
    .dir(dir_q), .ready(ready), .first_oper(first_oper));

  ulpi_su_idle_chk #(.DATA_W(DATA_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .released(released), .first_oper(first_oper),
    .link_data(link_data), .proto_err(proto_err));

  assign dir         = dir_q;
  assign phy_data_oe = dir_q;
  assign phy_data    = '0;
endmodule

// File: rtl/ulpi_startup_chk.sv
module ulpi_startup_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_stp,
  input logic              dir,
  input logic [DATA_W-1:0] phy_data,
  input logic              phy_data_oe,
  input logic              ready,
  input logic              proto_err
);
  p_idle_while_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> (phy_data_oe && (phy_data == '0)));

  p_dir_falls_stp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir) |-> !$past(link_stp));

  p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!dir && !phy_data_oe));

  p_ready_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!$past(dir) && !$past(ready)));

  p_err_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(ready));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind ulpi_startup_seq ulpi_startup_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_stp(link_stp), .dir(dir), .phy_data(phy_data),
  .phy_data_oe(phy_data_oe), .ready(ready), .proto_err(proto_err));

// File: tb/ulpi_startup_seq_tb.sv
module ulpi_startup_seq_tb_top;
  localparam int LOCK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_lock = 1'b0;
  logic       stp = 1'b0;
  logic [7:0] din = 8'h00;
  logic       dir, oe, ready, err;
  logic [7:0] dout;
  logic       dir_x, oe_x, ready_x, err_x;
  logic [7:0] dout_x;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ulpi_startup_seq #(.DATA_W(8), .USE_EXT_LOCK(1'b0), .LOCK_CYCLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .pll_lock(1'b0), .link_stp(stp), .link_data(din),
    .dir(dir), .phy_data(dout), .phy_data_oe(oe), .ready(ready), .proto_err(err));

  ulpi_startup_seq #(.DATA_W(8), .USE_EXT_LOCK(1'b1), .LOCK_CYCLES(LOCK)) dut_x (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .link_stp(stp), .link_data(din),
    .dir(dir_x), .phy_data(dout_x), .phy_data_oe(oe_x), .ready(ready_x), .proto_err(err_x));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: edges since release, phase number, lock count.
  int m_edges = 0;
  int m_phase = 0;
  int m_cnt   = 0;
  bit m_first = 1'b0;
  bit m_err   = 1'b0;

  always @(negedge rst_n) begin
    m_edges = 0; m_phase = 0; m_cnt = 0; m_first = 1'b0; m_err = 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit rel = (m_edges >= 2);
      automatic int ph  = m_phase;
      automatic bit lk  = (m_cnt == LOCK);
      if (ph == 4 && m_first && din != 8'h00 && rel) m_err = 1'b1;
      m_first = rel && (ph == 3);
      if (!rel) begin
        m_phase = 0; m_cnt = 0; m_err = 1'b0;
      end else begin
        if (m_cnt < LOCK) m_cnt++;
        if (ph == 0) m_phase = 1;
        else if (ph == 1 && lk) m_phase = 2;
        else if (ph == 2 && !stp) m_phase = 3;
        else if (ph == 3) m_phase = 4;
      end
      if (m_edges < 2) m_edges++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      automatic bit e_dir = (m_phase == 1 || m_phase == 2);
      chk("R3 model dir", int'(dir), int'(e_dir));
      chk("R3 model oe", int'(oe), int'(e_dir));
      if (dir) chk("R3 idle data", int'(dout), 0);
      chk("R6 model ready", int'(ready), int'(m_phase == 4));
      chk("R7 model proto_err", int'(err), int'(m_err));
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dir in reset", int'(dir), 0);
    chk("R1 oe in reset", int'(oe), 0);
    chk("R1 ready in reset", int'(ready), 0);
    chk("R1 err in reset", int'(err), 0);

    // Phase 1: release between edges, stp low, count edges.
    #5 rst_n = 1'b1;
    for (int e = 1; e <= LOCK + 5; e++) begin
      @(negedge clk);
      if (e == 2) chk("R2 dir after 2 edges", int'(dir), 0);
      if (e == 3) chk("R2 dir after 3 edges", int'(dir), 1);
      if (e == LOCK + 3) chk("R4 dir before lock edge", int'(dir), 1);
      if (e == LOCK + 4) begin
        chk("R4 dir falls", int'(dir), 0);
        chk("R6 turnaround oe", int'(oe), 0);
        chk("R6 turnaround ready", int'(ready), 0);
      end
      if (e == LOCK + 5) chk("R6 ready rises", int'(ready), 1);
    end
    @(negedge clk);
    chk("R7 idle link no error", int'(err), 0);
    din = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R7 later data ignored", int'(err), 0);
    din = 8'h00;

    // External lock instance still waiting.
    chk("R8 ext dir held without lock", int'(dir_x), 1);
    pll_lock = 1'b1;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      if (e == 3) chk("R8 ext dir before sync done", int'(dir_x), 1);
      if (e == 4) chk("R8 ext dir falls", int'(dir_x), 0);
    end

    // Phase 2: async reset mid-cycle from operational, then STP held.
    #5 rst_n = 1'b0;
    #1;
    chk("R9 ready cleared", int'(ready), 0);
    chk("R1 dir async", int'(dir), 0);
    chk("R1 oe async", int'(oe), 0);
    stp = 1'b1;
    @(negedge clk);
    #5 rst_n = 1'b1;
    repeat (LOCK + 60) @(negedge clk);
    chk("R5 dir held by stp", int'(dir), 1);
    stp = 1'b0;
    @(negedge clk);
    chk("R5 dir falls after stp low", int'(dir), 0);
    chk("R6 turnaround ready low", int'(ready), 0);
    @(negedge clk);
    chk("R6 ready after turnaround", int'(ready), 1);
    din = 8'h01;
    @(negedge clk);
    chk("R7 non-idle flagged", int'(err), 1);
    din = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 error sticky", int'(err), 1);

    // Phase 3: reset clears the error; replay with stp pulses.
    #5 rst_n = 1'b0;
    #1;
    chk("R9 err cleared by reset", int'(err), 0);
    @(negedge clk);
    #5 rst_n = 1'b1;
    repeat (LOCK / 2) @(negedge clk);
    stp = 1'b1;
    repeat (LOCK) @(negedge clk);
    stp = 1'b0;
    @(negedge clk);
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 replay reaches ready", int'(ready), 1);
    chk("R9 replay no error", int'(err), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule